// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block maps local 32-bit addresses onto a 36-bit outbound bus address space through a small set of programmable windows. Each window has a base page, a translation page, a 4-bit extension that supplies the upper outbound bits, and an attribute word. The attribute word holds an enable, a read transaction type, a write transaction type and a power-of-two size code. Windows are aligned to 4 KB pages. The size code is log2 of the window size in bytes, minus one.

Window 0 has no base. It catches every lookup that no other window claims. Windows 1 and up are matched against the local address, and on overlap the lowest index wins. Software programs the windows through a plain 32-bit register port. Lookups are presented with a valid strobe. One cycle later the unit returns the translated address, the two transaction types, the winning window index and a flag that tells a real hit from a default.

Top module: `outwin_xlat`

## Requirements
- R1: After reset, window 0's attribute reads 0x8004_4000 (enabled, read type 4, write type 4, size code 0). Every other register reads zero. All result outputs are zero until the first lookup.
- R2: Register byte offset bits 7:5 select the window and bits 4:0 select the field. The fields are: 0x00 translation page (bits 19:0 = address bits 31:12), 0x04 extension (bits 3:0 = outbound bits 35:32), 0x08 base page (bits 19:0) and 0x10 attribute. Any other field offset, and any window index of 5 or more, reads zero and ignores writes.
- R3: The attribute fields are: bit 31 enable, bits 19:16 read type, bits 15:12 write type, bits 5:0 size code. All other attribute bits read zero, so writing all ones reads back 0x800F_F03F.
- R4: Window w (1..4) matches when it is enabled, its size code c is at least 11, and the local address equals the base page on every bit at or above c+1.
- R5: The outbound address takes bits below c+1 from the local address, bits 31 down to c+1 from the translation page, and bits 35:32 from the extension of the selected window. The low 12 bits always come from the local address.
- R6: When several windows match, the lowest-numbered one is selected.
- R7: A lookup that matches no window uses window 0, reports index 0 and hit=0, and uses window 0's types. Window 0's enable bit has no effect. Its base register reads zero and ignores writes. For window 0, a size code below 11 acts as 4 KB.
- R8: A size code below 11 disables the window. A size code above 31 acts as 31, which means the window covers the whole local space.
- R9: The result appears exactly one cycle after a lookup, with res_valid high for that one cycle. Without a lookup, res_valid is low and the result fields hold their previous values.
- R10: A register write and a lookup in the same cycle: the lookup uses the register values from before the write, and the write applies to lookups from the next cycle on.
- R11: Writing zero to a window's attribute disables it, so later lookups in its range fall to the next matching window or to the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Local address to translate |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_addr | output | 36 | Translated outbound address |
| res_rtype | output | 4 | Read transaction type of the selected window |
| res_wtype | output | 4 | Write transaction type of the selected window |
| res_win | output | 3 | Index of the selected window |
| res_hit | output | 1 | 1 when a window 1..4 matched, 0 for the default |

## Verification
The register port and the lookup path can act in the same cycle. In that case a reprogrammed window must not affect a lookup sampled at the same edge. The bench provokes this by issuing a lookup into an enabled window in the very cycle that clears that window's attribute. It then repeats the lookup on the next cycle. A behavioural reference model computes every lookup before it applies that cycle's write, and every result is compared with it on each clock. The first result must still show the hit, and the second must fall to the default window.

// File: rtl/outwin_pkg.sv
`timescale 1ns/1ps
package outwin_pkg;
  localparam int LOC_AW      = 32;
  localparam int PAGE_SH     = 12;
  localparam int PG_W        = LOC_AW - PAGE_SH;
  localparam int EXT_W       = 4;
  localparam int TYPE_W      = 4;
  localparam int SZ_W        = 6;
  localparam int OUT_AW      = LOC_AW + EXT_W;
  localparam int MIN_SZ_CODE = PAGE_SH - 1;

  typedef struct packed {
    logic              en;
    logic [TYPE_W-1:0] rtype;
    logic [TYPE_W-1:0] wtype;
    logic [SZ_W-1:0]   size;
  } win_attr_t;

  localparam win_attr_t ATTR_DEF_RST = '{en: 1'b1, rtype: 4'h4, wtype: 4'h4, size: 6'd0};

  // page bits (address bits 31:12) that pass through from the local address
  function automatic logic [PG_W-1:0] keep_mask(input logic [SZ_W-1:0] size);
    int kept;
    logic [PG_W-1:0] m;
    kept = int'(size) + 1;
    if (kept < PAGE_SH) kept = PAGE_SH;
    if (kept > LOC_AW)  kept = LOC_AW;
    for (int j = 0; j < PG_W; j++) m[j] = ((j + PAGE_SH) < kept);
    return m;
  endfunction
endpackage

// File: rtl/outwin_regs.sv
`timescale 1ns/1ps
module outwin_regs
  import outwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int CFG_AW  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [31:0]                     cfg_wdata,
  output logic [31:0]                     cfg_rdata,
  output logic [NUM_WIN-1:0][PG_W-1:0]    xlat_q,
  output logic [NUM_WIN-1:0][EXT_W-1:0]   ext_q,
  output logic [NUM_WIN-1:0][PG_W-1:0]    base_q,
  output win_attr_t [NUM_WIN-1:0]         attr_q
);
  localparam int FLD_W = 5;
  localparam int IDX_W = CFG_AW - FLD_W;
  localparam logic [FLD_W-1:0] FLD_XLAT = 5'h00;
  localparam logic [FLD_W-1:0] FLD_EXT  = 5'h04;
  localparam logic [FLD_W-1:0] FLD_BASE = 5'h08;
  localparam logic [FLD_W-1:0] FLD_ATTR = 5'h10;

  logic [IDX_W-1:0] sel_idx;
  logic [FLD_W-1:0] sel_fld;
  assign sel_idx = cfg_addr[CFG_AW-1:FLD_W];
  assign sel_fld = cfg_addr[FLD_W-1:0];

  win_attr_t wr_attr;
  assign wr_attr = '{en: cfg_wdata[31], rtype: cfg_wdata[19:16],
                     wtype: cfg_wdata[15:12], size: cfg_wdata[SZ_W-1:0]};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic            sel_w;
    logic [PG_W-1:0] xlat_r, xlat_d;
    logic [EXT_W-1:0] ext_r, ext_d;
    win_attr_t       attr_r, attr_d;

    assign sel_w = cfg_we && (sel_idx == IDX_W'(w));

    always_comb begin
      xlat_d = xlat_r;
      ext_d  = ext_r;
      attr_d = attr_r;
      if (sel_w && sel_fld == FLD_XLAT) xlat_d = cfg_wdata[PG_W-1:0];
      if (sel_w && sel_fld == FLD_EXT)  ext_d  = cfg_wdata[EXT_W-1:0];
      if (sel_w && sel_fld == FLD_ATTR) attr_d = wr_attr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xlat_r <= '0;
        ext_r  <= '0;
        attr_r <= (w == 0) ? ATTR_DEF_RST : win_attr_t'('0);
      end else begin
        xlat_r <= xlat_d;
        ext_r  <= ext_d;
        attr_r <= attr_d;
      end
    end

    assign xlat_q[w] = xlat_r;
    assign ext_q[w]  = ext_r;
    assign attr_q[w] = attr_r;

    if (w == 0) begin : g_nobase
      assign base_q[w] = '0;
    end else begin : g_base
      logic [PG_W-1:0] base_r, base_d;
      always_comb begin
        base_d = base_r;
        if (sel_w && sel_fld == FLD_BASE) base_d = cfg_wdata[PG_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_r <= '0;
        else        base_r <= base_d;
      end
      assign base_q[w] = base_r;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(sel_idx) < NUM_WIN) begin
      case (sel_fld)
        FLD_XLAT: cfg_rdata = 32'(xlat_q[sel_idx]);
        FLD_EXT:  cfg_rdata = 32'(ext_q[sel_idx]);
        FLD_BASE: cfg_rdata = 32'(base_q[sel_idx]);
        FLD_ATTR: cfg_rdata = {attr_q[sel_idx].en, 11'b0, attr_q[sel_idx].rtype,
                               attr_q[sel_idx].wtype, 6'b0, attr_q[sel_idx].size};
        default:  cfg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/outwin_match.sv
`timescale 1ns/1ps
module outwin_match
  import outwin_pkg::*;
(
  input  logic [PG_W-1:0] page,
  input  logic [PG_W-1:0] base,
  input  win_attr_t       attr,
  output logic            hit
);
  logic [PG_W-1:0] keep;
  logic            size_ok;
  assign keep    = keep_mask(attr.size);
  assign size_ok = (attr.size >= SZ_W'(MIN_SZ_CODE));
  assign hit     = attr.en && size_ok && (((page ^ base) & ~keep) == '0);
endmodule

// File: rtl/outwin_pick.sv
`timescale 1ns/1ps
module outwin_pick
  import outwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int IDX_W   = 3
) (
  input  logic [LOC_AW-1:0]             loc_addr,
  input  logic [NUM_WIN-1:0]            hits,
  input  logic [NUM_WIN-1:0][PG_W-1:0]  xlat_q,
  input  logic [NUM_WIN-1:0][EXT_W-1:0] ext_q,
  input  win_attr_t [NUM_WIN-1:0]       attr_q,
  output logic [OUT_AW-1:0]             out_addr,
  output logic [TYPE_W-1:0]             out_rtype,
  output logic [TYPE_W-1:0]             out_wtype,
  output logic [IDX_W-1:0]              out_idx,
  output logic                          out_hit
);
  logic [IDX_W-1:0] sel;
  logic             any;
  win_attr_t        a_sel;
  logic [PG_W-1:0]  keep, page_out;

  // descending scan: the last (lowest) matching index overrides
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int w = NUM_WIN - 1; w >= 1; w--) begin
      if (hits[w]) begin
        sel = IDX_W'(w);
        any = 1'b1;
      end
    end
  end

  assign a_sel     = attr_q[sel];
  assign keep      = keep_mask(a_sel.size);
  assign page_out  = (xlat_q[sel] & ~keep) | (loc_addr[LOC_AW-1:PAGE_SH] & keep);
  assign out_addr  = {ext_q[sel], page_out, loc_addr[PAGE_SH-1:0]};
  assign out_rtype = a_sel.rtype;
  assign out_wtype = a_sel.wtype;
  assign out_idx   = sel;
  assign out_hit   = any;
endmodule

// File: rtl/outwin_xlat.sv
`timescale 1ns/1ps
module outwin_xlat
  import outwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int CFG_AW  = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              res_valid,
  output logic [35:0]       res_addr,
  output logic [3:0]        res_rtype,
  output logic [3:0]        res_wtype,
  output logic [IDX_W-1:0]  res_win,
  output logic              res_hit
);
  logic [NUM_WIN-1:0][PG_W-1:0]  xlat_q;
  logic [NUM_WIN-1:0][EXT_W-1:0] ext_q;
  logic [NUM_WIN-1:0][PG_W-1:0]  base_q;
  win_attr_t [NUM_WIN-1:0]       attr_q;
  logic [NUM_WIN-1:0]            hits;

  outwin_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xlat_q(xlat_q), .ext_q(ext_q), .base_q(base_q), .attr_q(attr_q)
  );

  assign hits[0] = 1'b0;
  for (genvar w = 1; w < NUM_WIN; w++) begin : g_match
    outwin_match u_match (
      .page(lk_addr[LOC_AW-1:PAGE_SH]), .base(base_q[w]),
      .attr(attr_q[w]), .hit(hits[w])
    );
  end

  logic [OUT_AW-1:0] nxt_addr;
  logic [TYPE_W-1:0] nxt_rtype, nxt_wtype;
  logic [IDX_W-1:0]  nxt_win;
  logic              nxt_hit;

  outwin_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .loc_addr(lk_addr), .hits(hits), .xlat_q(xlat_q), .ext_q(ext_q),
    .attr_q(attr_q), .out_addr(nxt_addr), .out_rtype(nxt_rtype),
    .out_wtype(nxt_wtype), .out_idx(nxt_win), .out_hit(nxt_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_rtype <= '0;
      res_wtype <= '0;
      res_win   <= '0;
      res_hit   <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_addr  <= nxt_addr;
        res_rtype <= nxt_rtype;
        res_wtype <= nxt_wtype;
        res_win   <= nxt_win;
        res_hit   <= nxt_hit;
      end
    end
  end
endmodule

// File: rtl/outwin_checker.sv
`timescale 1ns/1ps
module outwin_checker #(
  parameter int NUM_WIN = 5,
  parameter int IDX_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_addr,
  input logic [31:0]      cfg_rdata,
  input logic             lk_valid,
  input logic [31:0]      lk_addr,
  input logic             res_valid,
  input logic [35:0]      res_addr,
  input logic [IDX_W-1:0] res_win,
  input logic             res_hit
);
  AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid); // R9
  AST_RES_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid); // R9
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(res_addr) && $stable(res_win) && $stable(res_hit))); // R9
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (res_addr[11:0] == $past(lk_addr[11:0]))); // R5
  AST_DEFAULT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_win == '0)); // R7
  AST_HIT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_win != '0 && int'(res_win) < NUM_WIN)); // R6
  AST_DEF_NO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h08) |-> (cfg_rdata == 32'h0)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[4:0] == 5'h0C) |-> (cfg_rdata == 32'h0)); // R2
endmodule

bind outwin_xlat outwin_checker #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_outwin_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
  .res_addr(res_addr), .res_win(res_win), .res_hit(res_hit)
);

// File: tb/outwin_xlat_bench.sv
`timescale 1ns/1ps
module outwin_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic [35:0] res_addr;
  logic [3:0]  res_rtype, res_wtype;
  logic [2:0]  res_win;
  logic        res_hit;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  outwin_xlat u_outwin_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_addr(res_addr),
    .res_rtype(res_rtype), .res_wtype(res_wtype), .res_win(res_win),
    .res_hit(res_hit)
  );

  // behavioural reference model
  logic [19:0] m_xlat [5];
  logic [3:0]  m_ext  [5];
  logic [19:0] m_base [5];
  logic [31:0] m_attr [5];
  logic        e_valid;
  logic [35:0] e_addr;
  logic [3:0]  e_rt, e_wt;
  logic [2:0]  e_win;
  logic        e_hit;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic ref_lookup(input logic [31:0] a);
    int sel, sz, k;
    logic [63:0] mask, full;
    sel = 0;
    for (int w = 4; w >= 1; w--) begin
      sz = int'(m_attr[w][5:0]);
      if (m_attr[w][31] && sz >= 11) begin
        k = (sz + 1 > 32) ? 32 : sz + 1;
        if (k == 32 || ((a >> k) == ({m_base[w], 12'h000} >> k))) sel = w;
      end
    end
    sz = int'(m_attr[sel][5:0]);
    k = sz + 1;
    if (k < 12) k = 12;
    if (k > 32) k = 32;
    mask = (64'h1 << k) - 64'h1;
    full = {28'h0, m_ext[sel], m_xlat[sel], 12'h000};
    e_addr = 36'((full & ~mask) | ({32'h0, a} & mask));
    e_rt   = m_attr[sel][19:16];
    e_wt   = m_attr[sel][15:12];
    e_win  = 3'(sel);
    e_hit  = (sel != 0);
  endtask

  task automatic ref_write(input logic [7:0] ad, input logic [31:0] d);
    int idx;
    idx = int'(ad[7:5]);
    if (idx < 5) begin
      case (ad[4:0])
        5'h00: m_xlat[idx] = d[19:0];
        5'h04: m_ext[idx]  = d[3:0];
        5'h08: if (idx != 0) m_base[idx] = d[19:0];
        5'h10: m_attr[idx] = d & 32'h800F_F03F;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 5; w++) begin
        m_xlat[w] = '0; m_ext[w] = '0; m_base[w] = '0; m_attr[w] = '0;
      end
      m_attr[0] = 32'h8004_4000;
      e_valid = 1'b0; e_addr = '0; e_rt = '0; e_wt = '0; e_win = '0; e_hit = 1'b0;
    end else begin
      e_valid = lk_valid;
      if (lk_valid) ref_lookup(lk_addr);   // lookup sees pre-write state (R10)
      if (cfg_we) ref_write(cfg_addr, cfg_wdata);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "res_valid", 64'(res_valid), 64'(e_valid));
      chk(cur_req, "res_addr", 64'(res_addr), 64'(e_addr));
      chk(cur_req, "res_rtype", 64'(res_rtype), 64'(e_rt));
      chk(cur_req, "res_wtype", 64'(res_wtype), 64'(e_wt));
      chk(cur_req, "res_win", 64'(res_win), 64'(e_win));
      chk(cur_req, "res_hit", 64'(res_hit), 64'(e_hit));
    end
  end

  task automatic cyc(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                     input logic lv, input logic [31:0] la);
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd; lk_valid = lv; lk_addr = la;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] wa, input logic [31:0] wd);
    cyc(1'b1, wa, wd, 1'b0, 32'h0);
  endtask

  task automatic look(input logic [31:0] la);
    cyc(1'b0, 8'h00, 32'h0, 1'b1, la);
  endtask

  task automatic rd(input logic [7:0] ra, input logic [31:0] exp, input string req);
    cfg_we = 1'b0; cfg_addr = ra; lk_valid = 1'b0;
    #1;
    chk(req, "cfg_rdata", 64'(cfg_rdata), 64'(exp));
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents and default routing
    cur_req = "R1";
    rd(8'h10, 32'h8004_4000, "R1");
    rd(8'h30, 32'h0, "R1");
    rd(8'h00, 32'h0, "R1");
    look(32'h1234_5678);
    look(32'hFFFF_FFFF);
    // R2/R3: map layout and field masking
    cur_req = "R2";
    wr(8'h20, 32'hFFF5_0000);
    wr(8'h24, 32'hFFFF_FFF3);
    wr(8'h28, 32'h0001_0000);
    rd(8'h20, 32'h0005_0000, "R2");
    rd(8'h24, 32'h0000_0003, "R2");
    rd(8'h28, 32'h0001_0000, "R2");
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, 32'h0, "R2");
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, 32'h0, "R2");
    rd(8'h00, 32'h0, "R2");
    cur_req = "R3";
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h70, 32'h800F_F03F, "R3");
    wr(8'h70, 32'h0);
    rd(8'h70, 32'h0, "R3");
    // R4/R5: window 1, 16 MB, memory type
    cur_req = "R4";
    wr(8'h30, 32'h8004_4000 | 32'd23);
    look(32'h1012_3456);
    look(32'h10FF_FFFF);
    look(32'h1100_0000);
    cur_req = "R5";
    look(32'h1000_0ABC);
    // R6: window 2 inside window 1, window 3 elsewhere
    cur_req = "R6";
    wr(8'h48, 32'h0001_0020);
    wr(8'h40, 32'h0000_000A);
    wr(8'h50, 32'h8008_8000 | 32'd15);
    wr(8'h68, 32'h0002_0000);
    wr(8'h60, 32'h0007_FFFF);
    wr(8'h64, 32'h0000_0009);
    wr(8'h70, 32'h8004_400B);
    look(32'h1002_1234);
    look(32'h2000_0ABC);
    cur_req = "R7";
    look(32'h2000_1000);
    // R10: write clears window 1 in the same cycle as a lookup into it
    cur_req = "R10";
    cyc(1'b1, 8'h30, 32'h0, 1'b1, 32'h1012_3456);
    cur_req = "R11";
    look(32'h1012_3456);
    look(32'h1002_1234);
    // R8: tiny size disables, oversize covers everything
    cur_req = "R8";
    wr(8'h88, 32'h0003_0000);
    wr(8'h90, 32'h8004_4005);
    look(32'h3000_0000);
    wr(8'h84, 32'h0000_000C);
    wr(8'h90, 32'h8008_8000 | 32'd40);
    look(32'h3000_0000);
    look(32'h2000_0ABC);
    wr(8'h90, 32'h0);
    // R7: default window translation, base and enable ignored
    cur_req = "R7";
    wr(8'h08, 32'h000F_FFFF);
    rd(8'h08, 32'h0, "R7");
    wr(8'h00, 32'h000A_BCDE);
    wr(8'h04, 32'h0000_000F);
    wr(8'h10, 32'h0008_8000 | 32'd19);
    look(32'h7654_3210);
    look(32'h0000_0001);
    // R9: gaps and back-to-back lookups, fields hold while idle
    cur_req = "R9";
    cyc(1'b0, 8'h00, 32'h0, 1'b0, 32'hDEAD_BEEF);
    cyc(1'b0, 8'h00, 32'h0, 1'b0, 32'h1002_0000);
    look(32'h1002_FFFF);
    look(32'h1003_0000);
    look(32'h2000_0FFF);
    cyc(1'b0, 8'h00, 32'h0, 1'b0, 32'h0);
    cyc(1'b0, 8'h00, 32'h0, 1'b0, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule